// File: doc/BRIEF.md
# Boot ROM and Memory Bank Mapper

This block sits between an 8-bit CPU's 16-bit address bus and a 256 KiB RAM made of sixteen 16 KiB blocks, plus a boot ROM that the block treats as block 16. The CPU space is cut into four 16 KiB windows, selected by address bits 15:14. Window 3 is fixed on RAM block 0. Windows 0, 1 and 2 follow one of eight bank arrangements, picked by a 3-bit code that software writes through an I/O strobe. The mapping for window 0 is kept separately for reads and for writes.

After reset the boot ROM overlays reads of window 0, while writes to window 0 already land in RAM. This lets boot code copy itself into the RAM underneath the ROM. A second I/O strobe switches the overlay off for good. The overlay is a two-state machine. `OVL_BOOT` is the reset state, in which reads of window 0 go to the ROM. `OVL_RAM` is the state in which they follow the RAM write mapping. The only transition, named *rom release*, is taken from `OVL_BOOT` to `OVL_RAM` on any `rom_off_we` strobe. `OVL_RAM` holds until reset.

For each access the block produces the physical block number, the physical address, gated memory strobes, an open-bus flag, and the read data returned to the CPU.

Top module: `bank_mapper`

## Requirements
- R1: After reset, window 0 reads map to block 16 (ROM), window 0 writes to block 1, window 1 to block 2, window 2 to block 3 and window 3 to block 0.
- R2: The window is cpu_addr[15:14], and phys_addr is {phys_block[4:0], cpu_addr[13:0]} for every mapped access.
- R3: Window 3 always maps to block 0 and is never open bus, whatever the bank code or overlay state.
- R4: A rom_off_we pulse moves the overlay to OVL_RAM from the next cycle. Window 0 reads then use the window 0 write block. Further pulses and bank writes do not bring the ROM back; only reset does.
- R5: Only bank_data[2:0] is used as the bank code. Bits 7:3 have no effect on any mapping.
- R6: Codes 0 to 4 map windows 0, 1 and 2 to blocks 3n+1, 3n+2 and 3n+3.
- R7: Code 5 maps windows 0, 1 and 2 to blocks 1, 2 and 13. Code 7 maps them to blocks 1, 4 and 13.
- R8: Code 6 maps window 0 to block 14 and window 1 to block 15, and leaves window 2 unmapped. An access to window 2 then raises open_bus, holds mem_rd and mem_wr low, and returns 8'hFF on cpu_rdata.
- R9: While the overlay is in OVL_BOOT, a bank write changes the window 0 write block, but window 0 reads stay on block 16.
- R10: Mapping registers change only on a clock edge where bank_we is high. The new mapping is visible from the next cycle.
- R11: For mapped accesses, mem_rd and mem_wr follow cpu_rd and cpu_wr, and cpu_rdata equals mem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_off_we | input | 1 | I/O write strobe that releases the boot ROM overlay |
| bank_we | input | 1 | I/O write strobe for the bank code |
| bank_data | input | 8 | I/O write data; bits 2:0 are the bank code |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU memory read |
| cpu_wr | input | 1 | CPU memory write; selects the write mapping of window 0 |
| mem_rdata | input | 8 | Read data from the RAM/ROM arrays |
| phys_block | output | 5 | Physical block number (16 = ROM) |
| phys_addr | output | 19 | Physical byte address |
| mem_rd | output | 1 | Read strobe to the arrays, suppressed when unmapped |
| mem_wr | output | 1 | Write strobe to the arrays, suppressed when unmapped |
| open_bus | output | 1 | The addressed window has no block |
| cpu_rdata | output | 8 | Read data to the CPU |

## Verification
The bench sweeps all eight codes, each written with clear and with set upper data bits. Each code is checked in both overlay states, with reads and writes to all four windows, against a table computed in the bench.

The sweep targets specific failure modes:
- A design that let upper data bits leak into the code would map the wrong blocks on the set-bit pass.
- A design that forgot the read/write split of window 0 would send boot reads to RAM, or boot writes to the ROM.
- A design that moved the read block only at the moment of release would read a stale block after later bank writes.
- A design that let a bank write re-arm or drop the overlay would show up in the second sweep and after a second release pulse.
- With code 6, window 2 must raise open_bus, suppress both strobes and return 8'hFF; a design that returned array data or passed a write would be caught.
- A toggled bank_data with bank_we low must leave the mapping unchanged.

// File: rtl/bm_pkg.sv
package bm_pkg;

    localparam int BLK_W    = 5;
    localparam int WIN_W    = 2;
    localparam int CODE_W   = 3;
    localparam logic [BLK_W-1:0] ROM_BLK = 5'd16;
    localparam logic [BLK_W-1:0] TOP_BLK = 5'd0;

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic {
        OVL_BOOT,
        OVL_RAM
    } ovl_state_t;

    typedef struct packed {
        blk_t w0;
        blk_t w1;
        blk_t w2;
        logic w2_ok;
    } bank_map_t;

    localparam bank_map_t RESET_MAP = '{w0: 5'd1, w1: 5'd2, w2: 5'd3, w2_ok: 1'b1};

    // Translate a bank code into the blocks for windows 0..2.
    function automatic bank_map_t code_to_map(input logic [CODE_W-1:0] code);
        bank_map_t m;
        blk_t      n;
        n = {2'b00, code};
        m = RESET_MAP;
        unique case (code)
            3'd5: m = '{w0: 5'd1,  w1: 5'd2,  w2: 5'd13, w2_ok: 1'b1};
            3'd6: m = '{w0: 5'd14, w1: 5'd15, w2: 5'd0,  w2_ok: 1'b0};
            3'd7: m = '{w0: 5'd1,  w1: 5'd4,  w2: 5'd13, w2_ok: 1'b1};
            default: begin
                m.w0    = n + n + n + 5'd1;
                m.w1    = n + n + n + 5'd2;
                m.w2    = n + n + n + 5'd3;
                m.w2_ok = 1'b1;
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bm_overlay_fsm.sv
module bm_overlay_fsm
    import bm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rom_off_we,
    output logic rom_active
);

    ovl_state_t state_q;
    ovl_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVL_BOOT: if (rom_off_we) state_d = OVL_RAM;
            OVL_RAM:  state_d = OVL_RAM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OVL_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            OVL_BOOT: rom_active = 1'b1;
            OVL_RAM:  rom_active = 1'b0;
        endcase
    end

    // R4
    ram_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OVL_RAM) |=> (state_q == OVL_RAM));

    // R9
    boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OVL_BOOT && !rom_off_we) |=> (state_q == OVL_BOOT));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_off_we |=> !rom_active);

endmodule

// File: rtl/bm_bank_regs.sv
module bm_bank_regs
    import bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [CODE_W-1:0] bank_code,
    output bank_map_t         map_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       map_q <= RESET_MAP;
        else if (bank_we) map_q <= code_to_map(bank_code);
    end

    // R10
    map_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(map_q));

    // R6
    linear_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && bank_code < 3'd5) |=>
        (map_q.w1 == map_q.w0 + 5'd1 && map_q.w2 == map_q.w0 + 5'd2 && map_q.w2_ok));

    // R8
    code6_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && bank_code == 3'd6) |=> !map_q.w2_ok);

endmodule

// File: rtl/bm_window_decode.sv
module bm_window_decode
    import bm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int OFFS_W = ADDR_W - WIN_W
) (
    input  bank_map_t           map_q,
    input  logic                rom_active,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic [DATA_W-1:0]   mem_rdata,
    output blk_t                phys_block,
    output logic [BLK_W+OFFS_W-1:0] phys_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                open_bus,
    output logic [DATA_W-1:0]   cpu_rdata
);

    logic [WIN_W-1:0]  win;
    logic [OFFS_W-1:0] offs;

    assign win  = cpu_addr[ADDR_W-1 -: WIN_W];
    assign offs = cpu_addr[OFFS_W-1:0];

    always_comb begin
        phys_block = TOP_BLK;
        open_bus   = 1'b0;
        unique case (win)
            2'd0: phys_block = (rom_active && !cpu_wr) ? ROM_BLK : map_q.w0;
            2'd1: phys_block = map_q.w1;
            2'd2: begin
                phys_block = map_q.w2_ok ? map_q.w2 : TOP_BLK;
                open_bus   = !map_q.w2_ok;
            end
            2'd3: phys_block = TOP_BLK;
        endcase
    end

    assign phys_addr = {phys_block, offs};
    assign mem_rd    = cpu_rd && !open_bus;
    assign mem_wr    = cpu_wr && !open_bus;
    assign cpu_rdata = open_bus ? {DATA_W{1'b1}} : mem_rdata;

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int OFFS_W = ADDR_W - WIN_W,
    localparam int PA_W   = BLK_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rom_off_we,
    input  logic              bank_we,
    input  logic [DATA_W-1:0] bank_data,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [BLK_W-1:0]  phys_block,
    output logic [PA_W-1:0]   phys_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              open_bus,
    output logic [DATA_W-1:0] cpu_rdata
);

    logic      rom_active;
    bank_map_t map_q;
    logic      unused_bank_hi;

    assign unused_bank_hi = ^bank_data[DATA_W-1:CODE_W];

    bm_overlay_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rom_off_we (rom_off_we),
        .rom_active (rom_active)
    );

    bm_bank_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_we   (bank_we),
        .bank_code (bank_data[CODE_W-1:0]),
        .map_q     (map_q)
    );

    bm_window_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .map_q      (map_q),
        .rom_active (rom_active),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .mem_rdata  (mem_rdata),
        .phys_block (phys_block),
        .phys_addr  (phys_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .open_bus   (open_bus),
        .cpu_rdata  (cpu_rdata)
    );

    // R3
    top_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1 -: WIN_W] == 2'd3) |-> (phys_block == TOP_BLK && !open_bus));

    // R8
    open_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> (!mem_rd && !mem_wr && cpu_rdata == {DATA_W{1'b1}}));

    // R9
    boot_read_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_active && !cpu_wr && cpu_addr[ADDR_W-1 -: WIN_W] == 2'd0) |-> (phys_block == ROM_BLK));

endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rom_off_we = 1'b0;
    logic        bank_we = 1'b0;
    logic [7:0]  bank_data = 8'h00;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [4:0]  phys_block;
    logic [18:0] phys_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic        open_bus;
    logic [7:0]  cpu_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model state
    bit       m_rom  = 1'b1;
    int       m_code = 0;

    always #5 clk = ~clk;

    bank_mapper uut (
        .clk(clk), .rst_n(rst_n), .rom_off_we(rom_off_we), .bank_we(bank_we),
        .bank_data(bank_data), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .mem_rdata(mem_rdata), .phys_block(phys_block), .phys_addr(phys_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .open_bus(open_bus), .cpu_rdata(cpu_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (rom=%0d code=%0d addr=%h wr=%0d)",
                     req, act, exp, m_rom, m_code, cpu_addr, cpu_wr);
        end
    endtask

    // expected block for window/direction; -1 means unmapped
    function automatic int exp_block(input bit rom, input int code, input int win, input bit wr);
        int b0, b1, b2;
        if (code < 5) begin
            b0 = 3 * code + 1; b1 = b0 + 1; b2 = b0 + 2;
        end else if (code == 5) begin
            b0 = 1; b1 = 2; b2 = 13;
        end else if (code == 6) begin
            b0 = 14; b1 = 15; b2 = -1;
        end else begin
            b0 = 1; b1 = 4; b2 = 13;
        end
        case (win)
            0: return (rom && !wr) ? 16 : b0;
            1: return b1;
            2: return b2;
            default: return 0;
        endcase
    endfunction

    task automatic access(input int win, input int offs, input bit wr, input string req);
        int eb;
        @(negedge clk);
        cpu_addr  = {win[1:0], offs[13:0]};
        cpu_wr    = wr;
        cpu_rd    = !wr;
        mem_rdata = 8'h5A ^ offs[7:0];
        #2;
        eb = exp_block(m_rom, m_code, win, wr);
        if (eb < 0) begin
            chk(open_bus && !mem_rd && !mem_wr, "R8 unmapped strobes", {open_bus, mem_rd, mem_wr}, 3'b100);
            if (!wr) chk(cpu_rdata == 8'hFF, "R8 open bus data", cpu_rdata, 8'hFF);
        end else begin
            chk(phys_block == eb[4:0], req, phys_block, eb);
            chk(phys_addr == {eb[4:0], offs[13:0]}, "R2 physical address", phys_addr, {eb[4:0], offs[13:0]});
            chk(!open_bus && mem_rd == !wr && mem_wr == wr, "R11 strobes", {open_bus, mem_rd, mem_wr}, {1'b0, !wr, wr});
            if (!wr) chk(cpu_rdata == (8'h5A ^ offs[7:0]), "R11 read data", cpu_rdata, 8'h5A ^ offs[7:0]);
        end
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int w = 0; w < 4; w++) begin
            access(w, (w * 4661 + m_code * 97) & 16'h3FFF, 1'b0, (w == 3) ? "R3 top window" : req);
            access(w, (w * 1237 + 16'h3FFF - m_code) & 16'h3FFF, 1'b1, (w == 3) ? "R3 top window" : req);
        end
    endtask

    task automatic bank_write(input logic [7:0] d);
        @(negedge clk);
        bank_we = 1'b1; bank_data = d;
        @(negedge clk);
        bank_we = 1'b0;
        m_code = int'(d[2:0]);
    endtask

    task automatic rom_off;
        @(negedge clk);
        rom_off_we = 1'b1;
        @(negedge clk);
        rom_off_we = 1'b0;
        m_rom = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_rom = 1'b1; m_code = 0;
    endtask

    task automatic code_sweep(input string tag);
        for (int c = 0; c < 8; c++) begin
            for (int hi = 0; hi < 2; hi++) begin
                bank_write({(hi != 0) ? 5'b10110 : 5'b00000, c[2:0]});
                if (c < 5)       sweep(hi != 0 ? "R5 upper bits ignored" : (m_rom ? "R9 boot bank write" : "R6 linear code"));
                else             sweep(hi != 0 ? "R5 upper bits ignored" : (m_rom ? "R9 boot bank write" : "R7 irregular code"));
            end
        end
        if (tag.len() == 0) $display("sweep done");
    endtask

    initial begin
        do_reset();
        // R1 reset mapping
        sweep("R1 reset mapping");

        // R9 overlay active across all codes
        code_sweep("R9");

        // R10 data without strobe changes nothing
        bank_write(8'h02);
        @(negedge clk);
        bank_data = 8'h06;
        @(negedge clk);
        bank_data = 8'hFF;
        sweep("R10 no strobe");

        // R4 release: reads follow the write block of window 0
        rom_off();
        sweep("R4 after release");

        // R6, R7, R8 with RAM only
        code_sweep("R6");

        // R4 sticky: second pulse and more bank writes
        rom_off();
        bank_write(8'h04);
        sweep("R4 sticky");

        // R4 only reset restores the ROM
        do_reset();
        sweep("R4 reset restores ROM");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule